// File: doc/BRIEF.md
# Biphase Data Line Word Receiver

This block receives one serial data line carried in biphase code, with each bit cell sampled twice by a clock that runs at double the bit rate. It stays quiet until an external line-position detector gives a one-cycle enable. It then watches the incoming samples for a fixed start pattern. The moment that pattern completes also fixes which sample opens each bit cell for the rest of the line.

After the start pattern, the receiver decodes 8-bit words, most significant bit first. It copies a chosen subset of word positions into a receive bank and ignores the other words. Every decoded bit is checked for a coding violation, which means the two half-cells of a bit are equal. When the last captured word has finished, the block returns to idle. If the line contained no counted violation, it emits a single-cycle data-valid pulse. A later stage uses that pulse to accept the bank contents. Slicing, sync separation and readout belong to other blocks.

Top module: `dlr_rx`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it is released, `rx_bank` is all zero and `data_valid` and `line_err` are low.
- R2: Before the first `line_en` pulse, and between pulses, the receiver does not search. A start pattern on `din` with no preceding enable changes neither `rx_bank` nor `data_valid`.
- R3: After the `line_en` cycle, the receiver matches the start code (default 8'hE7) as 16 consecutive samples. Each code bit b appears as b then not-b, most significant bit first. The earliest possible match ends on the 16th sample after the enable cycle. The next sample opens the first half of word 3, where word 1 is run-in and word 2 is the start code.
- R4: A half-cell pair 1 then 0 decodes as bit 1, and a pair 0 then 1 decodes as bit 0. The bits of a word arrive most significant bit first.
- R5: Only words 5, 11, 12, 13 and 14 are stored. Slot s occupies `rx_bank[8s+7:8s]`: slot 0 holds word 5 and slots 1 to 4 hold words 11 to 14. Other words leave the bank unchanged. A stored word is written in the cycle after its last sample.
- R6: A pair of equal half-cells inside a stored word sets `line_err` one cycle after the second half. The bit takes the value of the first half. In the default variant, a violation inside a word that is not stored has no effect.
- R7: `data_valid` pulses high for exactly one cycle, the cycle after the last sample of word 14, if and only if the line had no counted violation. The bank is updated whether the line is clean or not.
- R8: A `line_en` pulse clears `line_err` in the next cycle and aborts any line in progress without a `data_valid` pulse. Decoding then starts again with a fresh search for the start code.
- R9: After word 14 the receiver is idle. Further start patterns and words are ignored until the next `line_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, two samples per bit cell |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_en | input | 1 | One-cycle pulse that arms the start-code search for this line |
| din | input | 1 | Sliced biphase sample |
| rx_bank | output | 40 | Receive bank, slot s at bits 8s+7..8s |
| data_valid | output | 1 | One-cycle pulse at the end of an error-free line |
| line_err | output | 1 | Sticky violation flag for the current line |

## Verification
On every cycle, the assertions check the following:
- `data_valid` lasts a single cycle and never coincides with a raised `line_err`.
- `data_valid` only follows a cycle in which the receiver was decoding.
- An enable always clears the error flag and suppresses the pulse.
- The bank holds still while no line is being decoded.

Some behaviours only the bench scenarios can show. These are the start-pattern phase lock, the bit polarity and word order in each bank slot, the split between stored and skipped words, and the rule that an unarmed or finished receiver ignores a start pattern. The bench shows them by comparing the ports every cycle with a behavioural model across clean, corrupted, aborted and unarmed lines.

// File: rtl/dlr_pkg.sv
package dlr_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_HUNT = 2'd1,
      ST_DATA = 2'd2
   } rx_state_e;

   // Expand a code word into its sample-level biphase pattern, MSB first,
   // each bit b giving the sample pair b, ~b.
   function automatic logic [63:0] code_samples(input logic [31:0] code,
                                                input int unsigned w);
      logic [63:0] p;
      p = '0;
      for (int i = 31; i >= 0; i--) begin
         if (i < int'(w)) p = {p[61:0], code[i], ~code[i]};
      end
      return p;
   endfunction

   function automatic int unsigned count_set(input logic [31:0] m);
      int unsigned n;
      n = 0;
      for (int i = 0; i < 32; i++) if (m[i]) n++;
      return n;
   endfunction

   // Index of the n-th set bit (0-based), counting from bit 0 upward.
   function automatic int unsigned nth_set(input logic [31:0] m,
                                           input int unsigned n);
      int unsigned seen;
      int unsigned pos;
      seen = 0;
      pos  = 0;
      for (int i = 0; i < 32; i++) begin
         if (m[i]) begin
            if (seen == n) pos = i;
            seen++;
         end
      end
      return pos;
   endfunction

   function automatic int unsigned top_set(input logic [31:0] m);
      int unsigned pos;
      pos = 0;
      for (int i = 0; i < 32; i++) if (m[i]) pos = i;
      return pos;
   endfunction

endpackage

// File: rtl/dlr_start_match.sv
module dlr_start_match #(
   parameter int unsigned WORD_W     = 8,
   parameter logic [31:0] START_CODE = 32'h0000_00E7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic run,
   input  logic din,
   output logic hit
);
   localparam int unsigned SMP    = 2 * WORD_W;
   localparam int unsigned FILL_W = $clog2(SMP);
   localparam logic [SMP-1:0] PAT = SMP'(dlr_pkg::code_samples(START_CODE, WORD_W));

   logic [SMP-2:0]    sreg_q;
   logic [FILL_W-1:0] fill_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg_q <= '0;
         fill_q <= '0;
      end else if (clr) begin
         sreg_q <= '0;
         fill_q <= '0;
      end else if (run) begin
         sreg_q <= {sreg_q[SMP-3:0], din};
         if (fill_q != FILL_W'(SMP - 1)) fill_q <= fill_q + 1'b1;
      end
   end

   assign hit = run && (fill_q == FILL_W'(SMP - 1)) && ({sreg_q, din} == PAT);

endmodule

// File: rtl/dlr_cell_decode.sv
module dlr_cell_decode (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic run,
   input  logic din,
   output logic bit_vld,
   output logic bit_val,
   output logic bit_bad
);
   logic phase_q;
   logic half_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= 1'b0;
         half_q  <= 1'b0;
      end else if (clr) begin
         phase_q <= 1'b0;
      end else if (run) begin
         if (!phase_q) half_q <= din;
         phase_q <= ~phase_q;
      end
   end

   assign bit_vld = run & phase_q;
   assign bit_val = half_q;
   assign bit_bad = ~(half_q ^ din);

endmodule

// File: rtl/dlr_word_seq.sv
module dlr_word_seq #(
   parameter int unsigned WORD_W     = 8,
   parameter int unsigned LINE_WORDS = 15,
   parameter int unsigned FIRST_WORD = 3
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              load,
   input  logic                              step,
   output logic [$clog2(LINE_WORDS+1)-1:0]   word_idx,
   output logic                              last_bit
);
   localparam int unsigned BIDX_W = $clog2(WORD_W);
   localparam int unsigned WIDX_W = $clog2(LINE_WORDS + 1);

   logic [BIDX_W-1:0] bit_q;
   logic [WIDX_W-1:0] word_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_q  <= '0;
         word_q <= WIDX_W'(FIRST_WORD);
      end else if (load) begin
         bit_q  <= '0;
         word_q <= WIDX_W'(FIRST_WORD);
      end else if (step) begin
         if (last_bit) begin
            bit_q  <= '0;
            word_q <= word_q + 1'b1;
         end else begin
            bit_q <= bit_q + 1'b1;
         end
      end
   end

   assign last_bit = (bit_q == BIDX_W'(WORD_W - 1));
   assign word_idx = word_q;

endmodule

// File: rtl/dlr_rx.sv
module dlr_rx #(
   parameter int unsigned WORD_W       = 8,
   parameter int unsigned LINE_WORDS   = 15,
   parameter int unsigned FIRST_WORD   = 3,
   parameter logic [31:0] CAPTURE_MASK = 32'h0000_7820,
   parameter logic [31:0] START_CODE   = 32'h0000_00E7,
   parameter bit          CHECK_ALL    = 1'b0,
   localparam int unsigned N_SLOTS     = dlr_pkg::count_set(CAPTURE_MASK),
   localparam int unsigned BANK_W      = N_SLOTS * WORD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_en,
   input  logic              din,
   output logic [BANK_W-1:0] rx_bank,
   output logic              data_valid,
   output logic              line_err
);
   import dlr_pkg::*;

   localparam int unsigned LAST_WORD = top_set(CAPTURE_MASK);
   localparam int unsigned WIDX_W    = $clog2(LINE_WORDS + 1);

   // elaboration-time parameter checks
   if (WORD_W < 2 || WORD_W > 32) begin : g_bad_width
      $error("dlr_rx: WORD_W must lie in 2..32");
   end
   if (LINE_WORDS > 31 || LAST_WORD > LINE_WORDS) begin : g_bad_line
      $error("dlr_rx: captured words must fit inside the line");
   end
   if ((CAPTURE_MASK & ((32'd1 << FIRST_WORD) - 32'd1)) != 32'd0) begin : g_bad_mask
      $error("dlr_rx: cannot capture words before the first data word");
   end
   if (N_SLOTS == 0) begin : g_no_slot
      $error("dlr_rx: CAPTURE_MASK selects no word");
   end

   rx_state_e         state_q;
   logic              hunt_run, data_run, hit;
   logic              bit_vld, bit_val, bit_bad, cnt_bad;
   logic [WIDX_W-1:0] word_idx;
   logic              last_bit, cap_now, line_end;
   logic [WORD_W-1:0] wsr_q;
   logic              err_q, valid_q;

   assign hunt_run = (state_q == ST_HUNT) & ~line_en;
   assign data_run = (state_q == ST_DATA) & ~line_en;

   dlr_start_match #(
      .WORD_W     (WORD_W),
      .START_CODE (START_CODE)
   ) i_match (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (line_en),
      .run   (hunt_run),
      .din   (din),
      .hit   (hit)
   );

   dlr_cell_decode i_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (line_en | hit),
      .run     (data_run),
      .din     (din),
      .bit_vld (bit_vld),
      .bit_val (bit_val),
      .bit_bad (bit_bad)
   );

   dlr_word_seq #(
      .WORD_W     (WORD_W),
      .LINE_WORDS (LINE_WORDS),
      .FIRST_WORD (FIRST_WORD)
   ) i_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (hit),
      .step     (bit_vld),
      .word_idx (word_idx),
      .last_bit (last_bit)
   );

   assign cap_now  = CAPTURE_MASK[word_idx];
   assign line_end = bit_vld & last_bit & (word_idx == WIDX_W'(LAST_WORD));

   // which violations count towards the line error
   if (CHECK_ALL) begin : g_chk_all
      assign cnt_bad = bit_bad;
   end else begin : g_chk_cap
      assign cnt_bad = bit_bad & cap_now;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
      end else if (line_en) begin
         state_q <= ST_HUNT;
      end else begin
         case (state_q)
            ST_HUNT: if (hit)      state_q <= ST_DATA;
            ST_DATA: if (line_end) state_q <= ST_IDLE;
            default: state_q <= state_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_q   <= 1'b0;
         valid_q <= 1'b0;
         wsr_q   <= '0;
      end else begin
         valid_q <= line_end & ~(err_q | cnt_bad);
         if (line_en)                err_q <= 1'b0;
         else if (bit_vld & cnt_bad) err_q <= 1'b1;
         if (bit_vld & cap_now) wsr_q <= {wsr_q[WORD_W-2:0], bit_val};
      end
   end

   for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
      localparam int unsigned WNUM = nth_set(CAPTURE_MASK, s);
      logic [WORD_W-1:0] slot_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) slot_q <= '0;
         else if (bit_vld && last_bit && word_idx == WIDX_W'(WNUM))
            slot_q <= {wsr_q[WORD_W-2:0], bit_val};
      end
      assign rx_bank[s*WORD_W +: WORD_W] = slot_q;
   end

   assign data_valid = valid_q;
   assign line_err   = err_q;

endmodule

// File: rtl/dlr_rx_chk.sv
module dlr_rx_chk #(
   parameter int unsigned BANK_W = 40
) (
   input logic              clk,
   input logic              rst_n,
   input logic              line_en,
   input logic              in_data,
   input logic [BANK_W-1:0] rx_bank,
   input logic              data_valid,
   input logic              line_err
);
   AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      data_valid |=> !data_valid);                                    // R7

   AST_VALID_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      data_valid |-> !line_err);                                      // R7

   AST_VALID_ENDS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      data_valid |-> $past(in_data));                                 // R7

   AST_ENABLE_CLEARS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      line_en |=> !line_err);                                         // R8

   AST_ENABLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      line_en |=> !data_valid);                                       // R8

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (line_err && !line_en) |=> line_err);                           // R6

   AST_BANK_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_data |=> $stable(rx_bank));                                 // R9

endmodule

bind dlr_rx dlr_rx_chk #(.BANK_W(BANK_W)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .line_en    (line_en),
   .in_data    (state_q == dlr_pkg::ST_DATA),
   .rx_bank    (rx_bank),
   .data_valid (data_valid),
   .line_err   (line_err)
);

// File: tb/test_dlr_rx.sv
module test_dlr_rx;
   localparam int CLK_PERIOD = 10;
   localparam logic [7:0] CODE   = 8'hE7;
   localparam logic [7:0] RUN_IN = 8'h55;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        line_en = 1'b0;
   logic        din = 1'b0;
   logic [39:0] rx_bank;
   logic        data_valid;
   logic        line_err;

   dlr_rx i_dlr_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_en    (line_en),
      .din        (din),
      .rx_bank    (rx_bank),
      .data_valid (data_valid),
      .line_err   (line_err)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk  = 0;
   int n_fail = 0;
   int vcnt   = 0;
   int cyc    = 0;
   bit started = 1'b0;

   logic [7:0] set_a [3:15];
   logic [7:0] set_b [3:15];

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
      end
   endtask

   function automatic int slot_of(input int w);
      case (w)
         5:  return 0;
         11: return 1;
         12: return 2;
         13: return 3;
         14: return 4;
         default: return -1;
      endcase
   endfunction

   // ---------------- behavioural reference model ----------------
   int         m_mode;         // 0 idle, 1 searching, 2 decoding
   bit         hist[$];
   bit         pat[$];
   int         m_k;
   bit         m_h;
   logic [7:0] m_acc;
   bit         m_err;
   bit         m_valid;
   logic [7:0] m_bank [0:4];

   initial begin
      for (int i = 7; i >= 0; i--) begin
         pat.push_back(CODE[i]);
         pat.push_back(~CODE[i]);
      end
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         m_mode = 0; hist.delete(); m_err = 0; m_valid = 0; m_acc = '0;
         for (int s = 0; s < 5; s++) m_bank[s] = '0;
      end else begin
         m_valid = 0;
         if (line_en) begin
            m_mode = 1; hist.delete(); m_err = 0;
         end else if (m_mode == 1) begin
            bit same;
            hist.push_back(din);
            if (hist.size() > 16) void'(hist.pop_front());
            same = (hist.size() == 16);
            for (int i = 0; i < hist.size(); i++) if (hist[i] != pat[i]) same = 0;
            if (same) begin m_mode = 2; m_k = 0; end
         end else if (m_mode == 2) begin
            if (m_k % 2 == 0) m_h = din;
            else begin
               int w, bi, sl;
               w  = 3 + m_k / 16;
               bi = (m_k / 2) % 8;
               sl = slot_of(w);
               if (sl >= 0) begin
                  if (m_h == din) m_err = 1;
                  m_acc = {m_acc[6:0], m_h};
                  if (bi == 7) m_bank[sl] = m_acc;
               end
               if (bi == 7 && w == 14) begin
                  m_mode = 0;
                  m_valid = !m_err;
               end
            end
            m_k++;
         end
      end
   end

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (started) begin
         chk("R7 data_valid", 64'(data_valid), 64'(m_valid));
         chk("R6 line_err", 64'(line_err), 64'(m_err));
         chk("R5 rx_bank", 64'(rx_bank),
             64'({m_bank[4], m_bank[3], m_bank[2], m_bank[1], m_bank[0]}));
         if (data_valid === 1'b1) vcnt++;
      end
   end

   always @(posedge clk) begin
      started <= 1'b1;
      cyc++;
      if (cyc > 50000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog R1..: actual=%0d expected<50000 cycles", cyc);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   task automatic put(input bit en, input bit d);
      @(negedge clk);
      line_en = en;
      din     = d;
   endtask

   task automatic send_byte(input logic [7:0] b, input int bad_bit);
      for (int i = 7; i >= 0; i--) begin
         put(0, b[i]);
         put(0, (7 - i == bad_bit) ? b[i] : ~b[i]);
      end
   endtask

   // set 0 = A, 1 = B; bad_word/bad_bit pick one corrupted cell (-1 none)
   task automatic send_line(input bit with_en, input int gap, input int last_w,
                            input int set, input int bad_w, input int bad_b);
      if (with_en) put(1, 0);
      for (int i = 0; i < gap; i++) put(0, 0);
      send_byte(RUN_IN, -1);
      send_byte(CODE, -1);
      for (int w = 3; w <= last_w; w++)
         send_byte(set == 0 ? set_a[w] : set_b[w], (w == bad_w) ? bad_b : -1);
      for (int i = 0; i < 4; i++) put(0, 0);
   endtask

   function automatic logic [39:0] bank_of(input int set);
      logic [7:0] s [0:4];
      int ws [0:4];
      ws = '{5, 11, 12, 13, 14};
      for (int i = 0; i < 5; i++) s[i] = (set == 0) ? set_a[ws[i]] : set_b[ws[i]];
      return {s[4], s[3], s[2], s[1], s[0]};
   endfunction

   initial begin
      int v0;
      for (int w = 3; w <= 15; w++) begin
         set_a[w] = 8'(8'h10 + w * 8'h11);
         set_b[w] = 8'(8'hC3 ^ (w * 37));
      end
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 reset bank", 64'(rx_bank), 64'd0);
      chk("R1 reset valid", 64'(data_valid), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after release err", 64'(line_err), 64'd0);

      // R2: start pattern with no enable is ignored
      v0 = vcnt;
      send_line(0, 3, 15, 0, -1, -1);
      chk("R2 no valid without enable", 64'(vcnt - v0), 64'd0);
      chk("R2 bank untouched", 64'(rx_bank), 64'd0);

      // R3 R4 R5 R7: clean line with a gap
      v0 = vcnt;
      send_line(1, 5, 15, 0, -1, -1);
      chk("R7 one valid pulse", 64'(vcnt - v0), 64'd1);
      chk("R4 R5 bank set A", 64'(rx_bank), 64'(bank_of(0)));

      // R3: start code right after the enable cycle
      v0 = vcnt;
      send_line(1, 0, 15, 1, -1, -1);
      chk("R3 earliest match valid", 64'(vcnt - v0), 64'd1);
      chk("R3 R4 bank set B", 64'(rx_bank), 64'(bank_of(1)));

      // R6: violation in a skipped word is ignored
      v0 = vcnt;
      send_line(1, 2, 15, 0, 7, 2);
      chk("R6 skipped word violation valid", 64'(vcnt - v0), 64'd1);
      chk("R6 skipped word err", 64'(line_err), 64'd0);

      // R6 R7: violation in a stored word
      v0 = vcnt;
      send_line(1, 2, 15, 1, 12, 3);
      chk("R7 no valid on error", 64'(vcnt - v0), 64'd0);
      chk("R6 err raised", 64'(line_err), 64'd1);
      chk("R7 bank still updated", 64'(rx_bank), 64'(bank_of(1)));

      // R8: abort a line, then a clean line
      v0 = vcnt;
      send_line(1, 1, 8, 0, 5, 0);
      chk("R8 err before abort", 64'(line_err), 64'd1);
      send_line(1, 1, 15, 1, -1, -1);
      chk("R8 restart valid once", 64'(vcnt - v0), 64'd1);
      chk("R8 err cleared", 64'(line_err), 64'd0);

      // R9: idle receiver ignores a further start pattern
      v0 = vcnt;
      send_line(0, 0, 15, 0, -1, -1);
      chk("R9 no valid when idle", 64'(vcnt - v0), 64'd0);
      chk("R9 bank held", 64'(rx_bank), 64'(bank_of(1)));

      repeat (4) @(negedge clk);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule